// File: doc/BRIEF.md
# Standby Entry and Wake Sequencer

This block sequences a microcontroller core into and out of a low-power standby state. Firmware sets a standby request bit in a small control register. The block then waits a fixed number of CPU clocks so that the core can run its stop instruction, and then raises a power-down output. That output gates the oscillator, the PLL and the analog blocks. While the request bit is set, the per-block analog enables from the rest of the chip are forced off.

A separate routing bit in the same register lets wake sources end standby. These are the user pins, the smart-card interface and the keypad, ORed together. Firmware must set the routing bit before it sets the request bit. A wake event clears the request bit and drops the power-down output. A stabilisation counter clocked by the CPU clock then runs for a fixed count, and only after that does the block raise a wake interrupt to the core. The interrupt is held until firmware accesses the control register. Reading the register also clears the routing bit.

Top module: `pwrseq_top`

## Requirements
- R1: After a register write that sets the standby request bit (bit 0), `pwr_down` stays low for 31 clock edges and is high after the 32nd edge following the write edge.
- R2: With the routing bit (bit 1) set, a one-cycle pulse on any user-pin source, on the card source or on the keypad source counts as a wake event.
- R3: A wake event while `pwr_down` is high drops `pwr_down` and clears the request bit at the clock edge that samples it, and `ana_en` follows `blk_pwr_en` again from then on.
- R4: `wake_irq` rises exactly 512 clock edges after the edge that sampled the wake event that ended standby, and not before.
- R5: `ctrl_rdata` shows the request bit at bit 0, the routing bit at bit 1, `pwr_down` at bit 2 and `wake_irq` at bit 3, with all other bits zero. A read cycle (`ctrl_rd` high, `ctrl_wr` low) clears the routing bit at its clock edge.
- R6: While the request bit is set, every bit of `ana_en` is 0 whatever `blk_pwr_en` holds. While it is clear, `ana_en` equals `blk_pwr_en`.
- R7: While the routing bit is clear, wake sources have no effect: `pwr_down` stays high and `ana_en` stays zero.
- R8: A wake event during the entry countdown aborts standby. `pwr_down` never rises, the request bit clears, and no wake interrupt follows.
- R9: `wake_irq` stays high until a register read or write, and it is low after the edge of that access.
- R10: After reset, `pwr_down` and `wake_irq` are low, the register reads 0x00, and `ana_en` equals `blk_pwr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_rd | input | 1 | Control register read strobe |
| ctrl_wdata | input | REG_W | Write data (bit 0 request, bit 1 routing) |
| ctrl_rdata | output | REG_W | Register read value |
| wake_user | input | N_USER | User-pin interrupt sources |
| wake_card | input | 1 | Smart-card interrupt source |
| wake_keypad | input | 1 | Keypad interrupt source |
| blk_pwr_en | input | N_BLK | Per-block analog power controls |
| pwr_down | output | 1 | Standby: gates oscillator, PLL and analog |
| ana_en | output | N_BLK | Effective analog block enables |
| wake_irq | output | 1 | Wake interrupt to the core |

## Verification
On every cycle, the assertions check several rules. Standby rises only after 31 cycles counted outside idle. A routed wake in the countdown or in standby releases `pwr_down` on the next edge. The interrupt fires only after a full stabilisation window. A read clears the routing bit. An unrouted standby holds until a write. A pending interrupt survives until a register access. The exact entry and exit cycle counts seen at the ports need the bench scenarios to show them. So do the routing of each source group, the readback field layout, and the rule that an aborted entry produces no interrupt even hundreds of cycles later.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ENTER = 2'd1,
    ST_DOWN  = 2'd2,
    ST_STAB  = 2'd3
  } seq_state_e;

  // control register field positions
  localparam int F_PD   = 0;
  localparam int F_WKEN = 1;
  localparam int F_PDN  = 2;
  localparam int F_IRQ  = 3;

  // true on the last count of a window of 'limit' cycles
  function automatic logic at_limit(input int unsigned cnt, input int unsigned limit);
    return cnt == limit - 1;
  endfunction

endpackage

// File: rtl/pwrseq_wake_router.sv
module pwrseq_wake_router #(
  parameter int N_USER = 8
) (
  input  logic              route_en,
  input  logic [N_USER-1:0] user_src,
  input  logic              card_src,
  input  logic              keypad_src,
  output logic              any_src,
  output logic              wake_evt
);

  always_comb begin
    any_src  = (|user_src) | card_src | keypad_src;
    wake_evt = route_en & any_src;
  end

endmodule

// File: rtl/pwrseq_ctrl_reg.sv
module pwrseq_ctrl_reg
  import pwrseq_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             rd,
  input  logic [REG_W-1:0] wdata,
  input  logic             seq_clear_pd,
  input  logic             irq_set,
  input  logic             pwr_down,
  output logic             pd_bit,
  output logic             wake_en,
  output logic             wake_irq,
  output logic [REG_W-1:0] rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_bit   <= 1'b0;
      wake_en  <= 1'b0;
      wake_irq <= 1'b0;
    end else begin
      if (wr) begin
        pd_bit  <= wdata[F_PD];
        wake_en <= wdata[F_WKEN];
      end else if (rd) begin
        wake_en <= 1'b0;
      end
      if (seq_clear_pd) pd_bit <= 1'b0;
      if (irq_set) wake_irq <= 1'b1;
      else if (wr || rd) wake_irq <= 1'b0;
    end
  end

  always_comb begin
    rdata         = '0;
    rdata[F_PD]   = pd_bit;
    rdata[F_WKEN] = wake_en;
    rdata[F_PDN]  = pwr_down;
    rdata[F_IRQ]  = wake_irq;
  end

  p_read_clears_route_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !wr) |=> !wake_en);

  p_irq_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_irq && !wr && !rd) |=> wake_irq);

endmodule

// File: rtl/pwrseq_seq.sv
module pwrseq_seq
  import pwrseq_pkg::*;
#(
  parameter int ENTRY_CYCLES = 32,
  parameter int EXIT_CYCLES  = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pd_bit,
  input  logic       wake_evt,
  output logic       pwr_down,
  output logic       seq_clear_pd,
  output logic       irq_set,
  output seq_state_e state
);

  localparam int MAXW = (ENTRY_CYCLES > EXIT_CYCLES) ? ENTRY_CYCLES : EXIT_CYCLES;
  localparam int CW   = $clog2(MAXW + 1);

  logic [CW-1:0] cnt;
  logic          entry_done;
  logic          stab_done;

  always_comb begin
    entry_done   = at_limit(32'(cnt), ENTRY_CYCLES);
    stab_done    = at_limit(32'(cnt), EXIT_CYCLES);
    irq_set      = (state == ST_STAB) && stab_done;
    seq_clear_pd = wake_evt && pd_bit &&
                   (state == ST_IDLE || state == ST_ENTER || state == ST_DOWN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      pwr_down <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (pd_bit && !wake_evt) begin
            state <= ST_ENTER;
            cnt   <= CW'(1);
          end
        end
        ST_ENTER: begin
          if (wake_evt || !pd_bit) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else if (entry_done) begin
            state    <= ST_DOWN;
            pwr_down <= 1'b1;
            cnt      <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DOWN: begin
          if (wake_evt) begin
            state    <= ST_STAB;
            pwr_down <= 1'b0;
            cnt      <= '0;
          end else if (!pd_bit) begin
            state    <= ST_IDLE;
            pwr_down <= 1'b0;
          end
        end
        ST_STAB: begin
          if (stab_done) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // independent age counters used only by the checks below
  logic [CW-1:0] busy_age;
  logic [CW-1:0] stab_age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_age <= '0;
      stab_age <= '0;
    end else begin
      busy_age <= (state == ST_IDLE) ? '0 :
                  ((32'(busy_age) < MAXW) ? busy_age + 1'b1 : busy_age);
      stab_age <= (state == ST_STAB) ? stab_age + 1'b1 : '0;
    end
  end

  p_entry_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_down) |-> (32'(busy_age) == ENTRY_CYCLES - 1));

  p_wake_releases_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DOWN && wake_evt) |=> !pwr_down);

  p_stab_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |-> (32'(stab_age) == EXIT_CYCLES - 1));

  p_abort_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ENTER && wake_evt) |=> (state == ST_IDLE && !pwr_down));

endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
  import pwrseq_pkg::*;
#(
  parameter int REG_W        = 8,
  parameter int N_USER       = 8,
  parameter int N_BLK        = 4,
  parameter int ENTRY_CYCLES = 32,
  parameter int EXIT_CYCLES  = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              ctrl_rd,
  input  logic [REG_W-1:0]  ctrl_wdata,
  output logic [REG_W-1:0]  ctrl_rdata,
  input  logic [N_USER-1:0] wake_user,
  input  logic              wake_card,
  input  logic              wake_keypad,
  input  logic [N_BLK-1:0]  blk_pwr_en,
  output logic              pwr_down,
  output logic [N_BLK-1:0]  ana_en,
  output logic              wake_irq
);

  logic       pd_bit;
  logic       wake_en;
  logic       any_src;
  logic       wake_evt;
  logic       seq_clear_pd;
  logic       irq_set;
  seq_state_e state;

  pwrseq_wake_router #(.N_USER(N_USER)) u_router (
    .route_en   (wake_en),
    .user_src   (wake_user),
    .card_src   (wake_card),
    .keypad_src (wake_keypad),
    .any_src    (any_src),
    .wake_evt   (wake_evt)
  );

  pwrseq_ctrl_reg #(.REG_W(REG_W)) u_reg (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr           (ctrl_wr),
    .rd           (ctrl_rd),
    .wdata        (ctrl_wdata),
    .seq_clear_pd (seq_clear_pd),
    .irq_set      (irq_set),
    .pwr_down     (pwr_down),
    .pd_bit       (pd_bit),
    .wake_en      (wake_en),
    .wake_irq     (wake_irq),
    .rdata        (ctrl_rdata)
  );

  pwrseq_seq #(.ENTRY_CYCLES(ENTRY_CYCLES), .EXIT_CYCLES(EXIT_CYCLES)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .pd_bit       (pd_bit),
    .wake_evt     (wake_evt),
    .pwr_down     (pwr_down),
    .seq_clear_pd (seq_clear_pd),
    .irq_set      (irq_set),
    .state        (state)
  );

  // request bit overrides each block's own power control
  for (genvar i = 0; i < N_BLK; i++) begin : g_ana
    assign ana_en[i] = blk_pwr_en[i] & ~pd_bit;
  end

  p_standby_gates_analog_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pwr_down) && !$past(ctrl_wr)) |-> (ana_en == '0));

  p_unrouted_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_down && !wake_en && !ctrl_wr && any_src) |=> pwr_down);

endmodule

// File: tb/pwrseq_top_tb.sv
module pwrseq_top_tb;

  localparam int REG_W  = 8;
  localparam int N_USER = 8;
  localparam int N_BLK  = 4;
  localparam int OW     = REG_W + 2 + N_BLK;
  localparam logic [N_BLK-1:0] BLK = 4'b1011;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              ctrl_wr, ctrl_rd;
  logic [REG_W-1:0]  ctrl_wdata, ctrl_rdata;
  logic [N_USER-1:0] wake_user;
  logic              wake_card, wake_keypad;
  logic [N_BLK-1:0]  blk_pwr_en, ana_en;
  logic              pwr_down, wake_irq;

  always #5 clk = ~clk;

  pwrseq_top #(.REG_W(REG_W), .N_USER(N_USER), .N_BLK(N_BLK)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_rd(ctrl_rd),
    .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata), .wake_user(wake_user),
    .wake_card(wake_card), .wake_keypad(wake_keypad), .blk_pwr_en(blk_pwr_en),
    .pwr_down(pwr_down), .ana_en(ana_en), .wake_irq(wake_irq)
  );

  typedef struct {
    string          req;
    logic [OW-1:0]  mask;
    logic [OW-1:0]  exp;
  } item_t;

  item_t q[$];
  int    n_vec  = 0;
  int    n_fail = 0;
  bit    done   = 0;

  logic [OW-1:0] obs;
  assign obs = {ctrl_rdata, wake_irq, pwr_down, ana_en};

  // monitor: compares queued expectations just after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        n_vec++;
        if ((obs & it.mask) !== (it.exp & it.mask)) begin
          n_fail++;
          $display("FAIL %s: got %h expected %h", it.req, obs & it.mask, it.exp & it.mask);
        end
      end
    end
  end

  task automatic exp_out(input string req, input logic irq, input logic pdn,
                         input logic [N_BLK-1:0] ana);
    item_t it;
    it.req  = req;
    it.mask = {{REG_W{1'b0}}, {(2 + N_BLK){1'b1}}};
    it.exp  = {{REG_W{1'b0}}, irq, pdn, ana};
    q.push_back(it);
  endtask

  task automatic reg_wr(input logic [REG_W-1:0] d);
    @(negedge clk);
    ctrl_wr = 1'b1; ctrl_wdata = d;
    @(negedge clk);
    ctrl_wr = 1'b0; ctrl_wdata = '0;
  endtask

  task automatic rd_chk(input string req, input logic [REG_W-1:0] v);
    item_t it;
    @(negedge clk);
    ctrl_rd = 1'b1;
    it.req  = req;
    it.mask = {{REG_W{1'b1}}, {(2 + N_BLK){1'b0}}};
    it.exp  = {v, {(2 + N_BLK){1'b0}}};
    q.push_back(it);
    @(negedge clk);
    ctrl_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; ctrl_wr = 1'b0; ctrl_rd = 1'b0; ctrl_wdata = '0;
    wake_user = '0; wake_card = 1'b0; wake_keypad = 1'b0; blk_pwr_en = BLK;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    exp_out("R10", 1'b0, 1'b0, BLK);
    rd_chk("R10", 8'h00);

    // R6: enables follow block controls when not requested
    @(negedge clk);
    blk_pwr_en = 4'b0110;
    exp_out("R6", 1'b0, 1'b0, 4'b0110);
    @(negedge clk);
    blk_pwr_en = BLK;

    // R5: readback layout and read-clears-routing
    reg_wr(8'h02);
    rd_chk("R5", 8'h02);
    rd_chk("R5", 8'h00);

    // R1/R2/R3/R4/R9: full cycle, woken by a user pin
    reg_wr(8'h02);
    reg_wr(8'h03);
    exp_out("R6", 1'b0, 1'b0, '0);
    idle(31);
    exp_out("R1", 1'b0, 1'b0, '0);
    idle(1);
    exp_out("R1", 1'b0, 1'b1, '0);
    idle(5);
    exp_out("R1", 1'b0, 1'b1, '0);
    @(negedge clk); wake_user = 8'h08;
    @(negedge clk); wake_user = '0;
    exp_out("R3", 1'b0, 1'b0, BLK);
    idle(511);
    exp_out("R4", 1'b0, 1'b0, BLK);
    idle(1);
    exp_out("R4", 1'b1, 1'b0, BLK);
    idle(20);
    exp_out("R9", 1'b1, 1'b0, BLK);
    rd_chk("R9", 8'h0A);
    exp_out("R9", 1'b0, 1'b0, BLK);
    rd_chk("R5", 8'h00);

    // R7: unrouted source ignored, then keypad wake after routing
    reg_wr(8'h01);
    idle(32);
    exp_out("R1", 1'b0, 1'b1, '0);
    @(negedge clk); wake_card = 1'b1;
    @(negedge clk); wake_card = 1'b0;
    idle(3);
    exp_out("R7", 1'b0, 1'b1, '0);
    reg_wr(8'h03);
    exp_out("R7", 1'b0, 1'b1, '0);
    @(negedge clk); wake_keypad = 1'b1;
    @(negedge clk); wake_keypad = 1'b0;
    exp_out("R2", 1'b0, 1'b0, BLK);
    idle(512);
    exp_out("R4", 1'b1, 1'b0, BLK);
    reg_wr(8'h00);
    exp_out("R9", 1'b0, 1'b0, BLK);

    // R8: card wake during entry countdown aborts
    reg_wr(8'h02);
    reg_wr(8'h03);
    idle(10);
    @(negedge clk); wake_card = 1'b1;
    @(negedge clk); wake_card = 1'b0;
    exp_out("R8", 1'b0, 1'b0, BLK);
    idle(40);
    exp_out("R8", 1'b0, 1'b0, BLK);
    idle(600);
    exp_out("R8", 1'b0, 1'b0, BLK);
    rd_chk("R8", 8'h02);

    idle(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

endmodule